// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits beside a cluster of four cores. For each core it gathers ten local request sources into a single IRQ line and a single FIQ line. The sources are four timer lines, four mailbox-active flags, one GPU request that all cores share, and one PMU request per core. Software uses a small word-addressed register port to choose where each source goes. Each core has its own bank with an enable byte for its timers and another for its mailboxes. Two global controls steer the shared GPU request and gate the PMU request for each core.

For every core, the block shows which enabled sources are currently asserted as two read-only pending words: one for IRQ and one for FIQ. The core's IRQ output is the OR of its IRQ pending word, and its FIQ output is the OR of its FIQ pending word. Whenever a source has both an FIQ enable and an IRQ enable set, it is delivered as FIQ. A source therefore never shows in both pending words of one core at once.

Top module: `core_irq_router`

## Requirements
- R1: After reset, all timer and mailbox enables, the GPU steering field and the PMU mask are zero. With no request asserted, every core output is low.
- R2: The timer control word of core c is at byte offset 0x40+4c. Bits [3:0] are the IRQ enables of timers 0-3 and bits [7:4] are their FIQ enables. A timer with its FIQ enable set is delivered only as FIQ, whatever its IRQ enable.
- R3: The mailbox control word of core c is at 0x50+4c. It has the same layout as the timer word and the same FIQ-over-IRQ rule, applied to the four mailbox-active flags of that core.
- R4: Pending words use this bit layout: bits 0-3 are timers 0-3, bits 4-7 are mailboxes 0-3, bit 8 is the GPU and bit 9 is the PMU. The IRQ pending word of core c reads at 0x60+4c and the FIQ pending word at 0x70+4c. Bits 31:10 read zero.
- R5: The GPU steering word is at 0x0C. Bits [1:0] name the core that takes the GPU request as IRQ, and bits [3:2] name the core that takes it as FIQ. When both fields name the same core, that core gets FIQ only. At reset both fields are 0, so core 0 takes the GPU request as FIQ.
- R6: A write to 0x10 sets the PMU enable of each core whose bit in [3:0] is 1. A write to 0x14 clears them. Reads of either offset return the mask. An enabled PMU request raises pending bit 9 in the IRQ word and never in the FIQ word.
- R7: Each core's IRQ output is high exactly when its IRQ pending word is nonzero. Each core's FIQ output is high exactly when its FIQ pending word is nonzero. Outputs follow the request inputs in the same cycle.
- R8: Writes to the pending offsets are ignored and leave every enable unchanged.
- R9: Unused bits of every word read zero, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Byte offset; bits [1:0] are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| timer_req | input | 16 | Timer requests, four per core, core c at [4c+3:4c] |
| mbox_active | input | 16 | Mailbox-active flags, four per core, same packing |
| gpu_req | input | 1 | Shared GPU request |
| pmu_req | input | 4 | PMU request per core |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
The hardest situation to reach is a clash: one source has both its IRQ and FIQ enables set, or the GPU steering fields name the same core twice. In that situation the FIQ-over-IRQ rule alone decides the result. The stimulus first sets only the IRQ enable, then writes the same control word again with the FIQ enable added while the request stays asserted. It also points both GPU fields at one core, then splits them across two cores. Every read then compares both pending words and all eight output lines against a model that keeps its own copy of the enables.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int SRC_N     = 10;
  localparam int TMR_BASE  = 0;
  localparam int MBX_BASE  = 4;
  localparam int GPU_BIT   = 8;
  localparam int PMU_BIT   = 9;
  localparam int LANES     = 4;

  localparam logic [3:0] GRP_GLOBAL = 4'h0;
  localparam logic [3:0] GRP_TMR    = 4'h4;
  localparam logic [3:0] GRP_MBX    = 4'h5;
  localparam logic [3:0] GRP_IPEND  = 4'h6;
  localparam logic [3:0] GRP_FPEND  = 4'h7;
  localparam logic [1:0] SLOT_GPU   = 2'd3;
  localparam logic [3:0] ADDR_PSET  = 4'h4;
  localparam logic [3:0] ADDR_PCLR  = 4'h5;

  // Returns {to_fiq, to_irq} for one request and its two enables.
  function automatic logic [1:0] steer(input logic raw, input logic ie, input logic fe);
    logic to_fiq;
    logic to_irq;
    to_fiq = raw & fe;
    to_irq = raw & ie & ~fe;
    return {to_fiq, to_irq};
  endfunction

  // Applies the PMU set/clear mask update.
  function automatic logic [LANES-1:0] mask_update(input logic [LANES-1:0] cur,
                                                   input logic [LANES-1:0] bits,
                                                   input logic is_set);
    return is_set ? (cur | bits) : (cur & ~bits);
  endfunction
endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               reg_wr,
  input  logic [ADDR_W-1:0]                  reg_addr,
  input  logic [DATA_W-1:0]                  reg_wdata,
  output logic [DATA_W-1:0]                  reg_rdata,
  input  logic [NUM_CORES-1:0][SRC_N-1:0]    irq_pend,
  input  logic [NUM_CORES-1:0][SRC_N-1:0]    fiq_pend,
  output logic [NUM_CORES-1:0][2*LANES-1:0]  tmr_en,
  output logic [NUM_CORES-1:0][2*LANES-1:0]  mbx_en,
  output logic [3:0]                         gpu_route,
  output logic [NUM_CORES-1:0]               pmu_en
);
  localparam int SLOT_W = 2;

  logic [3:0]        grp;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;
  logic              wr_tmr, wr_mbx, wr_gpu, wr_pset, wr_pclr, wr_pend;

  assign grp     = reg_addr[7:4];
  assign slot    = reg_addr[3:2];
  assign slot_ok = (32'(slot) < NUM_CORES);

  assign wr_tmr  = reg_wr && grp == GRP_TMR && slot_ok;
  assign wr_mbx  = reg_wr && grp == GRP_MBX && slot_ok;
  assign wr_gpu  = reg_wr && grp == GRP_GLOBAL && slot == SLOT_GPU;
  assign wr_pset = reg_wr && reg_addr[7:2] == ADDR_PSET;
  assign wr_pclr = reg_wr && reg_addr[7:2] == ADDR_PCLR;
  assign wr_pend = reg_wr && (grp == GRP_IPEND || grp == GRP_FPEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_en    <= '0;
      mbx_en    <= '0;
      gpu_route <= '0;
      pmu_en    <= '0;
    end else begin
      if (wr_tmr) tmr_en[slot] <= reg_wdata[2*LANES-1:0];
      if (wr_mbx) mbx_en[slot] <= reg_wdata[2*LANES-1:0];
      if (wr_gpu) gpu_route    <= reg_wdata[3:0];
      if (wr_pset) pmu_en <= mask_update(pmu_en, reg_wdata[NUM_CORES-1:0], 1'b1);
      else if (wr_pclr) pmu_en <= mask_update(pmu_en, reg_wdata[NUM_CORES-1:0], 1'b0);
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (grp)
      GRP_GLOBAL: begin
        if (slot == SLOT_GPU) reg_rdata[3:0] = gpu_route;
      end
      4'h1: begin
        if (slot == 2'd0 || slot == 2'd1) reg_rdata[NUM_CORES-1:0] = pmu_en;
      end
      GRP_TMR:   if (slot_ok) reg_rdata[2*LANES-1:0] = tmr_en[slot];
      GRP_MBX:   if (slot_ok) reg_rdata[2*LANES-1:0] = mbx_en[slot];
      GRP_IPEND: if (slot_ok) reg_rdata[SRC_N-1:0]   = irq_pend[slot];
      GRP_FPEND: if (slot_ok) reg_rdata[SRC_N-1:0]   = fiq_pend[slot];
      default:   reg_rdata = '0;
    endcase
  end

  // R8
  pend_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> $stable(tmr_en) && $stable(mbx_en) && $stable(pmu_en) && $stable(gpu_route));

  // R6
  pmu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pset |=> (pmu_en & $past(reg_wdata[NUM_CORES-1:0])) == $past(reg_wdata[NUM_CORES-1:0]));

  // R6
  pmu_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pclr |=> (pmu_en & $past(reg_wdata[NUM_CORES-1:0])) == '0);
endmodule

// File: rtl/irq_rt_core.sv
module irq_rt_core
  import irq_rt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     tmr_req,
  input  logic [LANES-1:0]     mbx_req,
  input  logic [2*LANES-1:0]   tmr_en,
  input  logic [2*LANES-1:0]   mbx_en,
  input  logic                 gpu_irq_hit,
  input  logic                 gpu_fiq_hit,
  input  logic                 pmu_hit,
  output logic [SRC_N-1:0]     irq_pend,
  output logic [SRC_N-1:0]     fiq_pend,
  output logic                 irq,
  output logic                 fiq
);
  logic [LANES-1:0][1:0] tmr_st;
  logic [LANES-1:0][1:0] mbx_st;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tmr_st[i] = steer(tmr_req[i], tmr_en[i], tmr_en[LANES+i]);
    assign mbx_st[i] = steer(mbx_req[i], mbx_en[i], mbx_en[LANES+i]);
    assign irq_pend[TMR_BASE+i] = tmr_st[i][0];
    assign fiq_pend[TMR_BASE+i] = tmr_st[i][1];
    assign irq_pend[MBX_BASE+i] = mbx_st[i][0];
    assign fiq_pend[MBX_BASE+i] = mbx_st[i][1];
  end

  assign irq_pend[GPU_BIT] = gpu_irq_hit;
  assign fiq_pend[GPU_BIT] = gpu_fiq_hit;
  assign irq_pend[PMU_BIT] = pmu_hit;
  assign fiq_pend[PMU_BIT] = 1'b0;

  assign irq = |irq_pend;
  assign fiq = |fiq_pend;

  // R2 R3 R5
  pend_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend & fiq_pend) == '0);

  // R2
  tmr_fiq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_req[0] && tmr_en[LANES]) |-> (fiq && !irq_pend[TMR_BASE]));
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_CORES*LANES-1:0] timer_req,
  input  logic [NUM_CORES*LANES-1:0] mbox_active,
  input  logic                       gpu_req,
  input  logic [NUM_CORES-1:0]       pmu_req,
  output logic [NUM_CORES-1:0]       core_irq,
  output logic [NUM_CORES-1:0]       core_fiq
);
  logic [NUM_CORES-1:0][SRC_N-1:0]   irq_pend;
  logic [NUM_CORES-1:0][SRC_N-1:0]   fiq_pend;
  logic [NUM_CORES-1:0][2*LANES-1:0] tmr_en;
  logic [NUM_CORES-1:0][2*LANES-1:0] mbx_en;
  logic [3:0]                        gpu_route;
  logic [NUM_CORES-1:0]              pmu_en;
  logic [NUM_CORES-1:0]              gpu_irq_hits;
  logic [NUM_CORES-1:0]              gpu_fiq_hits;

  irq_rt_regs #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_pend  (irq_pend),
    .fiq_pend  (fiq_pend),
    .tmr_en    (tmr_en),
    .mbx_en    (mbx_en),
    .gpu_route (gpu_route),
    .pmu_en    (pmu_en)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign gpu_fiq_hits[c] = gpu_req && 32'(gpu_route[3:2]) == c;
    assign gpu_irq_hits[c] = gpu_req && 32'(gpu_route[1:0]) == c && !gpu_fiq_hits[c];

    irq_rt_core u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .tmr_req     (timer_req[c*LANES +: LANES]),
      .mbx_req     (mbox_active[c*LANES +: LANES]),
      .tmr_en      (tmr_en[c]),
      .mbx_en      (mbx_en[c]),
      .gpu_irq_hit (gpu_irq_hits[c]),
      .gpu_fiq_hit (gpu_fiq_hits[c]),
      .pmu_hit     (pmu_req[c] && pmu_en[c]),
      .irq_pend    (irq_pend[c]),
      .fiq_pend    (fiq_pend[c]),
      .irq         (core_irq[c]),
      .fiq         (core_fiq[c])
    );
  end

  // R5
  gpu_single_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_fiq_hits) && $onehot0(gpu_irq_hits));

  // R5
  gpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gpu_req |-> (gpu_irq_hits == '0 && gpu_fiq_hits == '0));

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (tmr_en == '0 && mbx_en == '0 && pmu_en == '0 && gpu_route == '0));
endmodule

// File: tb/core_irq_router_test.sv
module core_irq_router_test;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] timer_req = '0;
  logic [15:0] mbox_active = '0;
  logic        gpu_req = 1'b0;
  logic [3:0]  pmu_req = '0;
  logic [3:0]  core_irq;
  logic [3:0]  core_fiq;

  core_irq_router uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_req(timer_req),
    .mbox_active(mbox_active), .gpu_req(gpu_req), .pmu_req(pmu_req),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  irq;
    logic [3:0]  fiq;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Bench-side shadow of software-visible state
  logic [7:0] m_tmr[NC];
  logic [7:0] m_mbx[NC];
  logic [3:0] m_gpu;
  logic [3:0] m_pmu;

  function automatic logic [31:0] model_pend(int c, bit want_fiq);
    logic [31:0] r;
    r = '0;
    for (int s = 0; s < 8; s++) begin
      logic req, ie, fe;
      if (s < 4) begin
        req = timer_req[c*4+s]; ie = m_tmr[c][s]; fe = m_tmr[c][s+4];
      end else begin
        req = mbox_active[c*4+s-4]; ie = m_mbx[c][s-4]; fe = m_mbx[c][s];
      end
      if (want_fiq) r[s] = req && fe;
      else          r[s] = req && ie && !fe;
    end
    if (want_fiq) r[8] = gpu_req && (int'(m_gpu[3:2]) == c);
    else          r[8] = gpu_req && (int'(m_gpu[1:0]) == c) && (int'(m_gpu[3:2]) != c);
    if (!want_fiq) r[9] = pmu_req[c] && m_pmu[c];
    return r;
  endfunction

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a[7:4] == 4'h4 && a[3:2] < NC) m_tmr[a[3:2]] = d[7:0];
    if (a[7:4] == 4'h5 && a[3:2] < NC) m_mbx[a[3:2]] = d[7:0];
    if (a[7:2] == 6'h03) m_gpu = d[3:0];
    if (a[7:2] == 6'h04) m_pmu = m_pmu | d[3:0];
    if (a[7:2] == 6'h05) m_pmu = m_pmu & ~d[3:0];
  endtask

  // Driver: pushes an expected item and waits for the monitor to consume it.
  task automatic expect_read(input string tag, input logic [7:0] a, input logic [31:0] d);
    item_t it;
    logic [3:0] ei, ef;
    for (int c = 0; c < NC; c++) begin
      ei[c] = |model_pend(c, 1'b0);
      ef[c] = |model_pend(c, 1'b1);
    end
    it.tag = tag; it.addr = a; it.data = d; it.irq = ei; it.fiq = ef;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // Monitor: applies the read address away from the edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q[0];
        reg_addr = it.addr;
        #1;
        checks++;
        if (reg_rdata !== it.data || core_irq !== it.irq || core_fiq !== it.fiq) begin
          fails++;
          $display("FAIL %s: addr=%h rdata=%h irq=%b fiq=%b expected rdata=%h irq=%b fiq=%b",
                   it.tag, it.addr, reg_rdata, core_irq, core_fiq, it.data, it.irq, it.fiq);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin m_tmr[c] = '0; m_mbx[c] = '0; end
    m_gpu = '0; m_pmu = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_read("R1 timer ctrl core0", 8'h40, 32'h0);
    expect_read("R1 gpu route", 8'h0C, 32'h0);
    expect_read("R1 pmu mask", 8'h10, 32'h0);

    // R2 R4 timer routing on core 1
    timer_req[7:4] = 4'b0011;
    write_reg(8'h44, 32'h0000_0021);
    expect_read("R2 core1 irq pending", 8'h64, model_pend(1, 0));
    expect_read("R4 core1 fiq pending", 8'h74, 32'h0000_0002);
    // R2 clash: FIQ wins for timer 0
    write_reg(8'h44, 32'h0000_0011);
    expect_read("R2 clash irq empty", 8'h64, 32'h0);
    expect_read("R2 clash fiq bit0", 8'h74, 32'h0000_0001);

    // R3 mailbox routing on core 2
    mbox_active[11:8] = 4'hF;
    write_reg(8'h58, 32'h0000_0084);
    expect_read("R3 core2 irq pending", 8'h68, 32'h0000_0040);
    expect_read("R3 core2 fiq pending", 8'h78, 32'h0000_0080);

    // R5 GPU steering
    timer_req = '0; mbox_active = '0;
    gpu_req = 1'b1;
    expect_read("R5 reset route fiq core0", 8'h70, 32'h0000_0100);
    write_reg(8'h0C, 32'h0000_000D);
    expect_read("R5 irq core1", 8'h64, 32'h0000_0100);
    expect_read("R5 fiq core3", 8'h7C, 32'h0000_0100);
    write_reg(8'h0C, 32'h0000_0005);
    expect_read("R5 same core irq empty", 8'h64, 32'h0);
    expect_read("R5 same core fiq", 8'h74, 32'h0000_0100);
    gpu_req = 1'b0;
    expect_read("R7 all quiet", 8'h74, 32'h0);

    // R6 PMU set/clear
    pmu_req = 4'hF;
    write_reg(8'h10, 32'h0000_0005);
    expect_read("R6 core2 irq pmu", 8'h68, 32'h0000_0200);
    expect_read("R6 core2 no fiq pmu", 8'h78, 32'h0);
    write_reg(8'h14, 32'h0000_0001);
    expect_read("R6 mask after clear", 8'h14, 32'h0000_0004);
    expect_read("R6 core0 cleared", 8'h60, 32'h0);

    // R8 write to pending offsets ignored
    write_reg(8'h68, 32'hFFFF_FFFF);
    write_reg(8'h70, 32'hFFFF_FFFF);
    expect_read("R8 core2 irq unchanged", 8'h68, 32'h0000_0200);
    expect_read("R8 timer ctrl unchanged", 8'h44, 32'h0000_0011);

    // R9 unused bits and holes
    write_reg(8'h4C, 32'hFFFF_FFFF);
    expect_read("R9 timer ctrl upper zero", 8'h4C, 32'h0000_00FF);
    expect_read("R9 unmapped offset", 8'h20, 32'h0);
    timer_req[15:12] = 4'h9;
    expect_read("R7 core3 fiq outputs", 8'h7C, 32'h0000_0009);
    pmu_req = '0; timer_req = '0;
    expect_read("R7 outputs low", 8'h6C, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule